// File: doc/BRIEF.md
# PCM DC Blocking Filter

This block removes the constant offset from a stream of signed PCM samples. It sits at the end of a PDM-to-PCM decimation chain, after the samples are already at their final rate. Each accepted sample runs through a first-order high-pass recurrence whose pole is one minus a power of two. The feedback term is therefore a subtract of a shifted copy of the accumulator, and the block needs no multiplier.

A 3-bit pole code sets the corner. Integration ties the code to 1 when no other value is wanted, which gives a pole of 1 - 2^-11. A bypass input lets test patterns through untouched, so their DC content is kept; constant and square-wave patterns are the intended use. While bypass is set, the recurrence keeps running, so filtering resumes cleanly when bypass is released.

Top module: `pcm_dc_remover`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_data` become 0, and both the previous-input and the accumulator state clear to zero. The first sample x after reset is therefore output as x (pole code 0..7, bypass low).
- R2: For each accepted sample the accumulator (scaled by 2^12) becomes y = 4096*(x[n] - x[n-1]) + y[n-1] - (y[n-1] >>> (12 - k)), where k is the unsigned value on `dc_code` and >>> is an arithmetic shift that truncates toward minus infinity.
- R3: The filtered output is the new accumulator plus 2048, shifted arithmetically right by 12, then saturated to the range -2^(DW-1) .. 2^(DW-1)-1 (DW = 16 by default).
- R4: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R5: Cycles with `in_valid` low leave the state and `out_data` unchanged. The next sample gives the same result as it would have with no gap.
- R6: A new value on `dc_code` applies from the next accepted sample. The accumulated state is not cleared.
- R7: With `bypass` high, `out_data` equals the accepted `in_data`, with the same one-cycle latency as the filtered path.
- R8: While `bypass` is high the state still advances by R2. The first filtered output after bypass drops equals the result of an uninterrupted filter.
- R9: With a constant input and code 7, the output falls to within ±1 of zero after 300 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| dc_code | input | 3 | Pole code k, pole = 1 - 2^-(12-k) |
| bypass | input | 1 | Pass input through unfiltered (debug) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW | Signed output sample |

## Verification
A wrong stored previous input shows on the very next accepted sample, because the difference term enters the output directly. A wrong accumulator value also appears on the next output, but it only fades with the pole's time constant, so the bench compares every output against an exact model rather than watching the settled level. State corruption during idle gaps or during bypass is caught on the first sample after the gap, or the first filtered sample after bypass ends. Saturation errors show only on full-scale steps, which get their own test.

// File: rtl/dcr_pkg.sv
// Shared constants and types for the DC blocking filter.
package dcr_pkg;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned POLE_BASE = 12;
    typedef logic [CODE_W-1:0] pole_code_t;
endpackage

// File: rtl/dcr_leak.sv
// Leak term of the recurrence: accumulator shifted right by (POLE_BASE - code).
// Assumes the accumulator is signed; the shift is arithmetic and truncates.
module dcr_leak #(
    parameter int YW = 30
) (
    input  logic signed [YW-1:0] acc,
    input  dcr_pkg::pole_code_t  code,
    output logic signed [YW-1:0] leak
);
    localparam int SHW = $clog2(dcr_pkg::POLE_BASE + 1);

    logic [SHW-1:0] shamt;

    // Convert the pole code into a shift distance and apply it.
    always_comb begin
        shamt = SHW'(dcr_pkg::POLE_BASE) - SHW'(code);
        leak  = acc >>> shamt;
    end
endmodule

// File: rtl/dcr_round_sat.sv
// Rounds a fixed-point accumulator (FRAC fraction bits) to an integer by adding
// one half and flooring, then clamps it to a DW-bit signed sample.
// Assumes YW > FRAC and DW <= YW - FRAC.
module dcr_round_sat #(
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int YW   = 30
) (
    input  logic signed [YW-1:0] acc,
    output logic signed [DW-1:0] sample
);
    localparam int WW = YW + 1 - FRAC;
    localparam logic signed [YW:0]   HALF = {{(YW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [WW-1:0] MAXV = WW'((64'sd1 <<< (DW-1)) - 1);
    localparam logic signed [WW-1:0] MINV = -MAXV - 1;

    logic signed [YW:0]   biased;
    logic signed [WW-1:0] whole;

    // Round half up, then clamp to the sample range.
    always_comb begin
        biased = $signed({acc[YW-1], acc}) + HALF;
        whole  = WW'(biased >>> FRAC);
        if (whole > MAXV)
            sample = MAXV[DW-1:0];
        else if (whole < MINV)
            sample = MINV[DW-1:0];
        else
            sample = whole[DW-1:0];
    end
endmodule

// File: rtl/pcm_dc_remover.sv
// First-order DC blocking filter for decimated PCM samples.
// y = (x - x_prev) * 2^FRAC + y - (y >>> (12 - code)); the output is y rounded
// and saturated, registered one cycle after in_valid. Bypass passes in_data
// with the same latency while the state keeps tracking. HEAD guard bits
// hold the worst-case gain of 2 of the high-pass response.
module pcm_dc_remover #(
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int HEAD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [2:0]           dc_code,
    input  logic                 bypass,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int YW = DW + HEAD + FRAC;

    logic signed [DW-1:0] x_prev;
    logic signed [YW-1:0] y_acc;
    logic signed [YW-1:0] x_ext;
    logic signed [YW-1:0] xp_ext;
    logic signed [YW-1:0] delta;
    logic signed [YW-1:0] leak;
    logic signed [YW-1:0] y_next;
    logic signed [DW-1:0] filt;

    dcr_leak #(.YW(YW)) leak_i (
        .acc  (y_acc),
        .code (dc_code),
        .leak (leak)
    );

    // Next accumulator value from the new sample and the stored state.
    always_comb begin
        x_ext  = YW'(in_data);
        xp_ext = YW'(x_prev);
        delta  = (x_ext - xp_ext) <<< FRAC;
        y_next = delta + y_acc - leak;
    end

    dcr_round_sat #(.DW(DW), .FRAC(FRAC), .YW(YW)) rsat_i (
        .acc    (y_next),
        .sample (filt)
    );

    // State and output registers; they advance only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev    <= '0;
            y_acc     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                x_prev   <= in_data;
                y_acc    <= y_next;
                out_data <= bypass ? in_data : filt;
            end
        end
    end

    // R1: reset clears the state
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (x_prev == '0 && y_acc == '0 && !out_valid));

    // R4: output strobe follows input strobe by one cycle
    p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: idle cycles hold state and output
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(x_prev) && $stable(y_acc) && $stable(out_data)));

    // R7: bypass presents the input sample unchanged
    p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass) |=> (out_data == $past(in_data)));

    // R8: stored input tracks the stream in every mode
    p_track_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (x_prev == $past(in_data)));
endmodule

// File: tb/pcm_dc_remover_tb_top.sv
`timescale 1ns/1ps
module pcm_dc_remover_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic [2:0]         dc_code = 3'd1;
    logic               bypass = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    longint m_xp = 0;
    longint m_y  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pcm_dc_remover dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .dc_code(dc_code), .bypass(bypass), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset for three edges; model state cleared as R1 states.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_data", out_data, 0);
        m_xp = 0; m_y = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one sample and compare the registered output with the model.
    task automatic push(input int x, input int k, input bit byp, input string req,
                        output longint got);
        longint d, lk, r, e;
        d    = (longint'(x) - m_xp) * 4096;
        lk   = m_y >>> (12 - k);
        m_y  = d + m_y - lk;
        m_xp = x;
        r = (m_y + 2048) >>> 12;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        e = byp ? longint'(x) : r;
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(x); dc_code = 3'(k); bypass = byp;
        @(posedge clk);
        #1;
        chk({req, " strobe R4"}, out_valid, 1);
        chk(req, out_data, e);
        got = out_data;
    endtask

    task automatic idle(input int n);
        longint held;
        @(negedge clk);
        in_valid = 1'b0;
        held = out_data;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk("R4 no strobe when idle", out_valid, 0);
            chk("R5 output held", out_data, held);
        end
    endtask

    task automatic t_first_sample();
        longint g;
        do_reset();
        push(1000, 1, 0, "R1 first sample passes", g);
        chk("R1 first sample value", g, 1000);
        push(1000, 1, 0, "R2 constant second", g);
        push(-500, 1, 0, "R2 negative step", g);
        idle(1);
    endtask

    task automatic t_gap_hold();
        longint g;
        do_reset();
        push(4000, 3, 0, "R2 code3", g);
        idle(3);
        push(4000, 3, 0, "R5 after gap", g);
        idle(2);
        push(-7000, 3, 0, "R5 after second gap", g);
        push(-7000, 3, 0, "R2 back to back", g);
    endtask

    task automatic t_code_change();
        longint g;
        do_reset();
        for (int i = 0; i < 5; i++) push(3000, 0, 0, "R2 code0", g);
        push(3000, 7, 0, "R6 switch to code7", g);
        push(3000, 7, 0, "R6 code7 continues", g);
        push(3000, 4, 0, "R6 switch to code4", g);
    endtask

    task automatic t_saturate();
        longint g;
        do_reset();
        push(32767, 7, 0, "R3 full-scale positive", g);
        chk("R3 top value", g, 32767);
        push(-32768, 7, 0, "R3 negative saturation", g);
        chk("R3 clamp low", g, -32768);
        push(32767, 7, 0, "R3 swing back", g);
        push(-32768, 7, 0, "R3 swing down", g);
    endtask

    task automatic t_bypass();
        longint g;
        do_reset();
        push(1200, 2, 0, "R2 pre-bypass", g);
        push(5000, 2, 1, "R7 bypass value", g);
        chk("R7 equals input", g, 5000);
        push(-32768, 2, 1, "R7 bypass extreme", g);
        push(5000, 2, 1, "R7 square high", g);
        push(-5000, 2, 0, "R8 first filtered after bypass", g);
        push(-5000, 2, 0, "R8 second filtered", g);
    endtask

    task automatic t_decay();
        longint g;
        do_reset();
        for (int i = 0; i < 300; i++) push(10000, 7, 0, "R9 constant input", g);
        chk("R9 residual within 1", (g >= -1 && g <= 1) ? 1 : 0, 1);
    endtask

    initial begin
        t_first_sample();
        t_gap_hold();
        t_code_change();
        t_saturate();
        t_bypass();
        t_decay();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule